// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Controller

This block arbitrates five interrupt sources for a small processor core. It keeps an enable register and a flag register, plus a master enable with three states: off, armed, and on. It also tracks whether the core is halted or stopped, and holds a single-fetch anomaly bit. Sources raise flag bits with one-cycle pulses. The core reads and writes both registers through a simple port, and it changes the master enable and the halt/stop state with one-cycle command strobes.

At every instruction boundary the core pulses `boundary`. On the next cycle the block reports one of four actions: execute normally, idle while halted, dispatch an interrupt, or stall because the core is stopped. A dispatch carries the handler address and the cycle cost. The core then pushes its program counter and jumps. The block makes these decisions and does not execute any instructions.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After a synchronous reset the enable register reads 0x00 and the flag register reads 0xE0. The master enable is off (code 0), and `halted`, `stopped` and `halt_bug` are all 0.
- R2: A write with `reg_wr_sel`=0 stores all 8 bits into the enable register. A write with `reg_wr_sel`=1 stores bits 4:0 into the flag register. Flag bits 7:5 always read as 1.
- R3: A pulse on `src_req[i]` sets flag bit i. If a dispatch clears that same bit in the same cycle, the request wins and the bit stays 1.
- R4: The pending set is enable[4:0] AND flag[4:0]. While halted and not stopped, a boundary with a nonzero pending set clears `halted`, whatever the master enable is. A boundary while halted with nothing pending reports action IDLE (code 1) with cost 4.
- R5: A boundary that finds the master enable armed (code 1) moves it to on (code 2). That boundary never dispatches, even when interrupts are pending.
- R6: The dispatched source is the lowest-numbered pending bit. Bit 0 has the highest priority and bit 4 the lowest. The handler address is 0x40 + 8 × bit index, reported on `step_vec`.
- R7: A boundary with the master enable on and a nonzero pending set reports DISPATCH (code 2) with cost 5. It turns the master enable off and clears only the serviced flag bit.
- R8: While stopped, a boundary reports STALL (code 3) with cost 0. It changes neither the master enable nor the flag register.
- R9: A halt command issued while the master enable is not on and the pending set is nonzero sets `halt_bug` and leaves `halted` at 0. `bug_done` clears `halt_bug`.
- R10: A boundary that neither dispatches nor idles reports EXEC (code 0) with cost 0. Every boundary produces exactly one `step_valid` pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 5 | One-cycle request pulses, bit 0 highest priority |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects the enable register, 1 selects the flag register |
| reg_wr_data | input | 8 | Write data |
| ime_ei | input | 1 | Arm the master enable (delayed enable) |
| ime_di | input | 1 | Turn the master enable off |
| ime_reti | input | 1 | Turn the master enable on immediately |
| halt_req | input | 1 | Halt command from the core |
| stop_req | input | 1 | Stop command from the core |
| bug_done | input | 1 | Core has consumed the anomalous fetch |
| boundary | input | 1 | Instruction boundary strobe |
| rd_enable | output | 8 | Enable register value |
| rd_flag | output | 8 | Flag register value, upper bits set |
| ime_state | output | 2 | Master enable: 0 off, 1 armed, 2 on |
| halted | output | 1 | Core halted |
| stopped | output | 1 | Core stopped |
| halt_bug | output | 1 | Single-fetch anomaly pending |
| step_valid | output | 1 | Boundary result valid |
| step_act | output | 2 | 0 EXEC, 1 IDLE, 2 DISPATCH, 3 STALL |
| step_vec | output | 16 | Handler address on dispatch |
| step_cost | output | 3 | Machine-cycle cost of the step |

## Verification
The assertions assume that the core never issues a master-enable, halt or stop command in the same cycle as a boundary strobe. They also assume that no register write coincides with a boundary. Without these assumptions the command would override the boundary's state change. The bench keeps commands and writes in cycles of their own and pulses `boundary` on its own. It sweeps every enable/flag pair over the five sources and then runs directed cases for halt, stop, the fetch anomaly and the set-over-clear race.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_SRC_DEF  = 5;
    localparam int REG_W        = 8;
    localparam int ADDR_W       = 16;
    localparam int COST_W       = 3;

    typedef enum logic [1:0] {
        IME_OFF   = 2'd0,
        IME_ARMED = 2'd1,
        IME_ON    = 2'd2
    } ime_e;

    typedef enum logic [1:0] {
        ACT_EXEC     = 2'd0,
        ACT_IDLE     = 2'd1,
        ACT_DISPATCH = 2'd2,
        ACT_STALL    = 2'd3
    } act_e;

    typedef struct packed {
        act_e               act;
        logic [ADDR_W-1:0]  vec;
        logic [COST_W-1:0]  cost;
    } step_res_t;

    localparam logic [COST_W-1:0] COST_DISPATCH = 3'd5;
    localparam logic [COST_W-1:0] COST_IDLE     = 3'd4;

    function automatic logic [ADDR_W-1:0] vec_of(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] stride,
                                                  input logic [ADDR_W-1:0] idx);
        return base + stride * idx;
    endfunction

endpackage

// File: rtl/irq_flag_regs.sv
module irq_flag_regs #(
    parameter int NUM_SRC = 5,
    parameter int REG_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [REG_W-1:0]   en_q,
    output logic [NUM_SRC-1:0] flag_q
);
    logic [NUM_SRC-1:0] flag_base;
    logic [NUM_SRC-1:0] flag_n;

    always_comb begin
        flag_base = (wr_en && wr_sel) ? wr_data[NUM_SRC-1:0] : flag_q;
        // request pulses are merged last so they win over a dispatch clear
        flag_n    = (flag_base & ~clr_mask) | src_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            flag_q <= flag_n;
            if (wr_en && !wr_sel)
                en_q <= wr_data;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = 5,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] onehot
);
    logic [NUM_SRC:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
        assign onehot[i]  = pend[i] & ~seen[i];
        assign seen[i+1]  = seen[i] | pend[i];
    end

    assign any = seen[NUM_SRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (onehot[i]) idx = idx | IDX_W'(i);
    end
endmodule

// File: rtl/irq_step_ctrl.sv
module irq_step_ctrl
    import irq_pkg::*;
#(
    parameter int                NUM_SRC  = 5,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'h0040,
    parameter logic [ADDR_W-1:0] VEC_STEP = 16'h0008,
    localparam int               IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boundary,
    input  logic               pend_any,
    input  logic [IDX_W-1:0]   pick_idx,
    input  logic [NUM_SRC-1:0] pick_onehot,
    input  logic               ime_ei,
    input  logic               ime_di,
    input  logic               ime_reti,
    input  logic               halt_req,
    input  logic               stop_req,
    input  logic               bug_done,
    output logic [NUM_SRC-1:0] clr_mask,
    output ime_e               ime_q,
    output logic               halted_q,
    output logic               stopped_q,
    output logic               bug_q,
    output logic               valid_q,
    output step_res_t          res_q
);
    ime_e      ime_n;
    logic      halted_n, stopped_n, bug_n;
    step_res_t res_n;
    logic      idle_now;

    always_comb begin
        ime_n     = ime_q;
        halted_n  = halted_q;
        stopped_n = stopped_q;
        bug_n     = bug_q;
        clr_mask  = '0;
        res_n     = '{act: ACT_EXEC, vec: '0, cost: '0};
        idle_now  = halted_q && !pend_any;

        if (boundary) begin
            if (stopped_q) begin
                res_n.act = ACT_STALL;
            end else begin
                if (pend_any) halted_n = 1'b0;
                if (ime_q == IME_ARMED) begin
                    ime_n = IME_ON;
                    if (idle_now) begin
                        res_n.act  = ACT_IDLE;
                        res_n.cost = COST_IDLE;
                    end
                end else if (ime_q == IME_ON && pend_any) begin
                    ime_n      = IME_OFF;
                    clr_mask   = pick_onehot;
                    res_n.act  = ACT_DISPATCH;
                    res_n.cost = COST_DISPATCH;
                    res_n.vec  = vec_of(VEC_BASE, VEC_STEP, ADDR_W'(pick_idx));
                end else if (idle_now) begin
                    res_n.act  = ACT_IDLE;
                    res_n.cost = COST_IDLE;
                end
            end
        end

        // core commands override the boundary update
        if (ime_di)   ime_n = IME_OFF;
        if (ime_ei)   ime_n = IME_ARMED;
        if (ime_reti) ime_n = IME_ON;
        if (halt_req) begin
            if (pend_any && ime_q != IME_ON) bug_n = 1'b1;
            else                             halted_n = 1'b1;
        end
        if (stop_req) stopped_n = 1'b1;
        if (bug_done) bug_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ime_q     <= IME_OFF;
            halted_q  <= 1'b0;
            stopped_q <= 1'b0;
            bug_q     <= 1'b0;
            valid_q   <= 1'b0;
            res_q     <= '{act: ACT_EXEC, vec: '0, cost: '0};
        end else begin
            ime_q     <= ime_n;
            halted_q  <= halted_n;
            stopped_q <= stopped_n;
            bug_q     <= bug_n;
            valid_q   <= boundary;
            if (boundary) res_q <= res_n;
        end
    end
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
    import irq_pkg::*;
#(
    parameter int                NUM_SRC  = 5,
    parameter logic [15:0]       VEC_BASE = 16'h0040,
    parameter logic [15:0]       VEC_STEP = 16'h0008
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               reg_wr_en,
    input  logic               reg_wr_sel,
    input  logic [7:0]         reg_wr_data,
    input  logic               ime_ei,
    input  logic               ime_di,
    input  logic               ime_reti,
    input  logic               halt_req,
    input  logic               stop_req,
    input  logic               bug_done,
    input  logic               boundary,
    output logic [7:0]         rd_enable,
    output logic [7:0]         rd_flag,
    output logic [1:0]         ime_state,
    output logic               halted,
    output logic               stopped,
    output logic               halt_bug,
    output logic               step_valid,
    output logic [1:0]         step_act,
    output logic [15:0]        step_vec,
    output logic [2:0]         step_cost
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int PAD_W = REG_W - NUM_SRC;

    logic [REG_W-1:0]   en_q;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] pick_onehot;
    logic [IDX_W-1:0]   pick_idx;
    logic               pend_any;
    ime_e               ime_q;
    step_res_t          res_q;

    irq_flag_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_sel   (reg_wr_sel),
        .wr_data  (reg_wr_data),
        .src_req  (src_req),
        .clr_mask (clr_mask),
        .en_q     (en_q),
        .flag_q   (flag_q)
    );

    assign pend = en_q[NUM_SRC-1:0] & flag_q;

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .pend   (pend),
        .any    (pend_any),
        .idx    (pick_idx),
        .onehot (pick_onehot)
    );

    irq_step_ctrl #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .boundary    (boundary),
        .pend_any    (pend_any),
        .pick_idx    (pick_idx),
        .pick_onehot (pick_onehot),
        .ime_ei      (ime_ei),
        .ime_di      (ime_di),
        .ime_reti    (ime_reti),
        .halt_req    (halt_req),
        .stop_req    (stop_req),
        .bug_done    (bug_done),
        .clr_mask    (clr_mask),
        .ime_q       (ime_q),
        .halted_q    (halted),
        .stopped_q   (stopped),
        .bug_q       (halt_bug),
        .valid_q     (step_valid),
        .res_q       (res_q)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_flag = {{PAD_W{1'b1}}, flag_q};
        end else begin : g_nopad
            assign rd_flag = flag_q[REG_W-1:0];
        end
    endgenerate

    assign rd_enable = en_q;
    assign ime_state = ime_q;
    assign step_act  = res_q.act;
    assign step_vec  = res_q.vec;
    assign step_cost = res_q.cost;
endmodule

// File: rtl/irq_dispatch_checker.sv
module irq_dispatch_checker (
    input logic        clk,
    input logic        rst,
    input logic        boundary,
    input logic [7:0]  rd_enable,
    input logic [7:0]  rd_flag,
    input logic [1:0]  ime_state,
    input logic        halted,
    input logic        stopped,
    input logic        halt_bug,
    input logic        step_valid,
    input logic [1:0]  step_act,
    input logic [15:0] step_vec,
    input logic [2:0]  step_cost
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (rd_enable == 8'h00 && ime_state == 2'd0 && !halted && !stopped && !halt_bug)); // R1

    AST_ARMED_NO_DISPATCH: assert property (@(posedge clk) disable iff (rst)
        (boundary && !stopped && ime_state == 2'd1) |=> (step_act != 2'd2 && ime_state == 2'd2)); // R5

    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        (step_valid && step_act == 2'd2) |-> (step_vec[2:0] == 3'd0 && step_vec >= 16'h0040 && step_vec <= 16'h0060)); // R6

    AST_DISPATCH_OFF: assert property (@(posedge clk) disable iff (rst)
        (step_valid && step_act == 2'd2) |-> (ime_state == 2'd0 && step_cost == 3'd5)); // R7

    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (rst)
        (boundary && halted && !stopped && (rd_enable[4:0] & rd_flag[4:0]) != 5'd0) |=> !halted); // R4

    AST_STOP_STALL: assert property (@(posedge clk) disable iff (rst)
        (boundary && stopped) |=> (step_act == 2'd3 && step_cost == 3'd0 && $stable(ime_state))); // R8

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        boundary |=> step_valid); // R10

    AST_EXEC_FREE: assert property (@(posedge clk) disable iff (rst)
        (step_valid && step_act == 2'd0) |-> step_cost == 3'd0); // R10
endmodule

bind irq_dispatch_ctrl irq_dispatch_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .boundary   (boundary),
    .rd_enable  (rd_enable),
    .rd_flag    (rd_flag),
    .ime_state  (ime_state),
    .halted     (halted),
    .stopped    (stopped),
    .halt_bug   (halt_bug),
    .step_valid (step_valid),
    .step_act   (step_act),
    .step_vec   (step_vec),
    .step_cost  (step_cost)
);

// File: tb/irq_dispatch_ctrl_test.sv
module irq_dispatch_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  src_req;
    logic        reg_wr_en, reg_wr_sel;
    logic [7:0]  reg_wr_data;
    logic        ime_ei, ime_di, ime_reti, halt_req, stop_req, bug_done, boundary;
    logic [7:0]  rd_enable, rd_flag;
    logic [1:0]  ime_state;
    logic        halted, stopped, halt_bug, step_valid;
    logic [1:0]  step_act;
    logic [15:0] step_vec;
    logic [2:0]  step_cost;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dispatch_ctrl uut (
        .clk(clk), .rst(rst), .src_req(src_req),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .ime_ei(ime_ei), .ime_di(ime_di), .ime_reti(ime_reti),
        .halt_req(halt_req), .stop_req(stop_req), .bug_done(bug_done),
        .boundary(boundary),
        .rd_enable(rd_enable), .rd_flag(rd_flag), .ime_state(ime_state),
        .halted(halted), .stopped(stopped), .halt_bug(halt_bug),
        .step_valid(step_valid), .step_act(step_act),
        .step_vec(step_vec), .step_cost(step_cost)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rst = 1'b0; src_req = '0; reg_wr_en = 1'b0; reg_wr_sel = 1'b0; reg_wr_data = '0;
        ime_ei = 1'b0; ime_di = 1'b0; ime_reti = 1'b0; halt_req = 1'b0;
        stop_req = 1'b0; bug_done = 1'b0; boundary = 1'b0;
    endtask

    // one clock edge; inputs were set after a falling edge, results sampled at the next one
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        rst = 1'b1; step();
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d; step();
    endtask

    task automatic bnd();
        boundary = 1'b1; step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 enable", rd_enable, 8'h00);
        chk("R1 flag", rd_flag, 8'hE0);
        chk("R1 ime", ime_state, 2'd0);
        chk("R1 halt/stop/bug", {halted, stopped, halt_bug}, 3'b000);

        // R2 register access
        wr(1'b0, 8'hA5); chk("R2 enable full width", rd_enable, 8'hA5);
        wr(1'b1, 8'h00); chk("R2 flag upper ones", rd_flag, 8'hE0);
        wr(1'b1, 8'h0A); chk("R2 flag low bits", rd_flag, 8'hEA);

        // R3 pulses set bits
        wr(1'b1, 8'h00);
        src_req = 5'h10; step(); chk("R3 pulse sets", rd_flag, 8'hF0);

        // R3 set wins over dispatch clear
        do_reset();
        wr(1'b0, 8'h01); wr(1'b1, 8'h01);
        ime_reti = 1'b1; step();
        boundary = 1'b1; src_req = 5'h01; step();
        chk("R3 dispatch act", step_act, 2'd2);
        chk("R3 set wins", rd_flag, 8'hE1);

        // R6 R7 R5 R10 sweep over every enable/flag pair
        for (int en = 0; en < 32; en++) begin
            for (int fl = 0; fl < 32; fl++) begin
                int pend;
                int pick;
                pend = en & fl;
                pick = -1;
                for (int b = 4; b >= 0; b--) if (pend[b]) pick = b;
                do_reset();
                wr(1'b0, 8'(en)); wr(1'b1, 8'(fl));
                ime_ei = 1'b1; step();
                chk("R5 armed", ime_state, 2'd1);
                bnd();
                chk("R5 no dispatch when armed", {step_valid, step_act}, {1'b1, 2'd0});
                chk("R5 armed becomes on", ime_state, 2'd2);
                bnd();
                if (pick >= 0) begin
                    chk("R6 vector", {step_act, step_vec}, {2'd2, 16'(16'h40 + 8 * pick)});
                    chk("R7 cost and ime off", {step_cost, ime_state}, {3'd5, 2'd0});
                    chk("R7 single bit cleared", rd_flag, 8'hE0 | 8'(fl & ~(1 << pick)));
                end else begin
                    chk("R10 exec", {step_valid, step_act, step_cost}, {1'b1, 2'd0, 3'd0});
                    chk("R10 ime stays on", ime_state, 2'd2);
                end
            end
        end

        // R4 idle while halted, wake with master enable off
        do_reset();
        halt_req = 1'b1; step();
        chk("R4 halted", halted, 1'b1);
        bnd();
        chk("R4 idle step", {step_act, step_cost}, {2'd1, 3'd4});
        chk("R4 still halted", halted, 1'b1);
        wr(1'b0, 8'h04);
        src_req = 5'h04; step();
        bnd();
        chk("R4 wake ime off", halted, 1'b0);
        chk("R4 exec after wake", step_act, 2'd0);

        // R9 halt anomaly
        do_reset();
        wr(1'b0, 8'h02); wr(1'b1, 8'h02);
        halt_req = 1'b1; step();
        chk("R9 bug set, not halted", {halt_bug, halted}, 2'b10);
        bug_done = 1'b1; step();
        chk("R9 bug cleared", halt_bug, 1'b0);

        // R8 stopped
        do_reset();
        wr(1'b0, 8'h1F); wr(1'b1, 8'h1F);
        ime_ei = 1'b1; step();
        stop_req = 1'b1; step();
        bnd();
        chk("R8 stall", {step_act, step_cost}, {2'd3, 3'd0});
        chk("R8 ime unchanged", ime_state, 2'd1);
        chk("R8 flags unchanged", rd_flag, 8'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule